// File: doc/BRIEF.md
# Ring Command Queue Consumer

This block drains a ring of commands that software places in memory for an interrupt translation unit. Software programs an enable bit and a write offset. Whenever the unit is enabled, no stall is pending and the write offset differs from the internal read offset, the block fetches one 32-byte entry as four 64-bit doublewords through a single-outstanding read request/response port. It then classifies the opcode and presents the whole entry to a downstream command executor. Once the executor accepts the entry without error, the read offset advances by one and wraps at the end of the ring.

The ring starts at a byte base address and holds 128 entries per 4 KB page; the page count is a configuration input. The block validates a write offset against the ring size and refuses to start when the offset is outside the ring. A failed fetch, or an error reported by the executor, freezes the queue on the failing entry and raises a stalled flag. Software clears the stall by rewriting the write pointer with its retry bit set.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset, `rptr_reg`, `wptr_reg`, `busy`, `mem_req_valid` and `cmd_valid` are all zero.
- R2: A register write to address 0 sets the enable from data bit 0. A write to address 1 loads the write offset from data bits [19:5]. `wptr_reg` shows that offset in bits [19:5] and zero in every other bit. Writes to addresses 2 and 3 have no effect.
- R3: No fetch starts while the enable is clear, while the queue is stalled, or while the write offset equals the read offset.
- R4: When the write offset is not below the entry count (128 times `q_pages`), no fetch starts and `busy` stays low. This also holds when `q_pages` is zero.
- R5: An entry at read offset N is fetched with four requests to addresses `q_base + 32*N + 8*k`, for k = 0, 1, 2, 3 in that order. Only one request is outstanding at a time. A request and its address are held until `mem_req_ready`.
- R6: `cmd_dw` carries doubleword k in bits [64k+63:64k], and `cmd_opcode` is bits [7:0] of doubleword 0. `cmd_kind` encodes 0x03→1, 0x04→2, 0x05→3, 0x08→4, 0x09→5, 0x0A→6, 0x0B→7, 0x0F→8. `cmd_valid` holds its entry until `cmd_ready`.
- R7: Any other opcode gives `cmd_kind` 0, and the entry is still presented and consumed.
- R8: An entry accepted without `cmd_err` advances the read offset by one, modulo the entry count. The read offset is shown in `rptr_reg[19:5]`. The offset changes at no other time.
- R9: A fetch response with `mem_rsp_err` or an accepted entry with `cmd_err` sets `rptr_reg[0]` and leaves the read offset on the failing entry. After that, no request or command is issued.
- R10: Only a write-pointer write with data bit 0 set clears the stall. Processing then restarts at the same entry.
- R11: `busy` is high while an entry is in flight and whenever a fetch is eligible to start.
- R12: Clearing the enable lets the entry in flight complete and starts no further entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register select: 0 control, 1 write pointer |
| reg_wr_data | input | 32 | Register write data |
| q_base | input | ADDR_W | Byte base address of the ring |
| q_pages | input | PAGES_W | Ring size in 4 KB pages |
| wptr_reg | output | 32 | Write pointer register view |
| rptr_reg | output | 32 | Read pointer register view, bit 0 stalled |
| busy | output | 1 | Commands in flight or pending |
| mem_req_valid | output | 1 | Doubleword read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | ADDR_W | Byte address of requested doubleword |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response data |
| mem_rsp_err | input | 1 | Read response error |
| cmd_valid | output | 1 | Entry offered to executor |
| cmd_ready | input | 1 | Executor accepts entry |
| cmd_opcode | output | 8 | Raw opcode byte |
| cmd_kind | output | 4 | Classified opcode |
| cmd_dw | output | 256 | Complete entry, doubleword 0 in the low bits |
| cmd_err | input | 1 | Executor reports failure with `cmd_ready` |

## Verification
On every cycle, the assertions check the handshake rules: request and entry hold until accepted, fetch and dispatch are never active together, and `busy` covers all activity. They also check that the read offset moves only after an error-free acceptance, that a stall appears only after a reported error, and that nothing is issued while stalled. Only the bench scenarios can show the values themselves. These include the fetch address sequence, the opcode classification table, wraparound at the ring end, refusal of out-of-range offsets, the exact retry behaviour after each kind of error, and the completion of one entry after the enable is cleared.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;
    localparam int OFF_W          = 15;  // entry offset field width
    localparam int OFF_LSB        = 5;   // offset field starts at bit 5
    localparam int REG_W          = 32;
    localparam int DW_W           = 64;
    localparam int DW_PER_CMD     = 4;
    localparam int IDX_W          = $clog2(DW_PER_CMD);
    localparam int ENTRY_W        = DW_W * DW_PER_CMD;
    localparam int ENTRY_B_LOG2   = 5;   // 32 bytes per entry
    localparam int DW_B_LOG2      = 3;   // 8 bytes per doubleword
    localparam int PAGE_ENT_LOG2  = 7;   // 4096 / 32 entries per page
    localparam int OPC_W          = 8;
    localparam int KIND_W         = 4;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_WPTR = 2'd1;

    localparam logic [OPC_W-1:0] OPC_TRIGGER   = 8'h03;
    localparam logic [OPC_W-1:0] OPC_CLEAR     = 8'h04;
    localparam logic [OPC_W-1:0] OPC_SYNC      = 8'h05;
    localparam logic [OPC_W-1:0] OPC_MAP_DEV   = 8'h08;
    localparam logic [OPC_W-1:0] OPC_MAP_COLL  = 8'h09;
    localparam logic [OPC_W-1:0] OPC_MAP_XLATE = 8'h0A;
    localparam logic [OPC_W-1:0] OPC_MAP_ID    = 8'h0B;
    localparam logic [OPC_W-1:0] OPC_DISCARD   = 8'h0F;

    typedef enum logic [KIND_W-1:0] {
        K_NOP       = 4'd0,
        K_TRIGGER   = 4'd1,
        K_CLEAR     = 4'd2,
        K_SYNC      = 4'd3,
        K_MAP_DEV   = 4'd4,
        K_MAP_COLL  = 4'd5,
        K_MAP_XLATE = 4'd6,
        K_MAP_ID    = 4'd7,
        K_DISCARD   = 4'd8
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_EXEC = 2'd3
    } fetch_st_e;
endpackage

// File: rtl/cmdq_regs.sv
`timescale 1ns/1ps
module cmdq_regs
    import cmdq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              enable,
    output logic [OFF_W-1:0]  wr_off,
    output logic              retry
);
    typedef struct packed {
        logic             enable;
        logic [OFF_W-1:0] wr_off;
    } regs_t;

    regs_t regs_q, regs_d;
    logic  unused_data;

    assign unused_data = ^{wr_data[REG_W-1:OFF_LSB+OFF_W], wr_data[OFF_LSB-1:1]};

    always_comb begin
        regs_d = regs_q;
        retry  = 1'b0;
        if (wr_en && wr_addr == REG_CTRL) begin
            regs_d.enable = wr_data[0];
        end
        if (wr_en && wr_addr == REG_WPTR) begin
            regs_d.wr_off = wr_data[OFF_LSB +: OFF_W];
            retry         = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign enable = regs_q.enable;
    assign wr_off = regs_q.wr_off;
endmodule

// File: rtl/cmdq_decode.sv
`timescale 1ns/1ps
module cmdq_decode
    import cmdq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output cmd_kind_e        kind
);
    always_comb begin
        case (opcode)
            OPC_TRIGGER:   kind = K_TRIGGER;
            OPC_CLEAR:     kind = K_CLEAR;
            OPC_SYNC:      kind = K_SYNC;
            OPC_MAP_DEV:   kind = K_MAP_DEV;
            OPC_MAP_COLL:  kind = K_MAP_COLL;
            OPC_MAP_XLATE: kind = K_MAP_XLATE;
            OPC_MAP_ID:    kind = K_MAP_ID;
            OPC_DISCARD:   kind = K_DISCARD;
            default:       kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/cmdq_fetch.sv
`timescale 1ns/1ps
module cmdq_fetch
    import cmdq_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int PAGES_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic               retry,
    input  logic [ADDR_W-1:0]  q_base,
    input  logic [PAGES_W-1:0] q_pages,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [DW_W-1:0]    mem_rsp_data,
    input  logic               mem_rsp_err,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    input  logic               cmd_err,
    output logic [ENTRY_W-1:0] cmd_dw,
    output logic [OFF_W-1:0]   rd_off,
    output logic               stalled,
    output logic               busy
);
    localparam int ENT_W = PAGES_W + PAGE_ENT_LOG2;
    localparam int CMP_W = ((ENT_W > OFF_W) ? ENT_W : OFF_W) + 1;

    typedef struct packed {
        fetch_st_e                           st;
        logic [IDX_W-1:0]                    idx;
        logic [OFF_W-1:0]                    rd_off;
        logic                                stalled;
        logic [DW_PER_CMD-1:0][DW_W-1:0]     dw;
    } fetch_t;

    fetch_t fs_q, fs_d;

    logic [CMP_W-1:0] n_ent, wr_ext, rd_inc;
    logic [OFF_W-1:0] rd_next;
    logic             in_range, pending;

    assign n_ent    = CMP_W'({q_pages, {PAGE_ENT_LOG2{1'b0}}});
    assign wr_ext   = CMP_W'(wr_off);
    assign rd_inc   = CMP_W'(fs_q.rd_off) + CMP_W'(1);
    assign rd_next  = (rd_inc >= n_ent) ? '0 : OFF_W'(rd_inc);
    assign in_range = wr_ext < n_ent;
    assign pending  = enable && !fs_q.stalled && (wr_off != fs_q.rd_off) && in_range;

    always_comb begin
        fs_d = fs_q;
        if (retry) fs_d.stalled = 1'b0;
        unique case (fs_q.st)
            ST_IDLE: begin
                if (pending) begin
                    fs_d.st  = ST_REQ;
                    fs_d.idx = '0;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) fs_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        fs_d.stalled = 1'b1;
                        fs_d.st      = ST_IDLE;
                    end else begin
                        fs_d.dw[fs_q.idx] = mem_rsp_data;
                        if (fs_q.idx == IDX_W'(DW_PER_CMD - 1)) begin
                            fs_d.st = ST_EXEC;
                        end else begin
                            fs_d.idx = fs_q.idx + 1'b1;
                            fs_d.st  = ST_REQ;
                        end
                    end
                end
            end
            ST_EXEC: begin
                if (cmd_ready) begin
                    if (cmd_err) fs_d.stalled = 1'b1;
                    else         fs_d.rd_off  = rd_next;
                    fs_d.st = ST_IDLE;
                end
            end
            default: fs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign mem_req_valid = (fs_q.st == ST_REQ);
    assign mem_req_addr  = q_base
                         + ADDR_W'({fs_q.rd_off, {ENTRY_B_LOG2{1'b0}}})
                         + ADDR_W'({fs_q.idx, {DW_B_LOG2{1'b0}}});
    assign cmd_valid     = (fs_q.st == ST_EXEC);
    assign cmd_dw        = fs_q.dw;
    assign rd_off        = fs_q.rd_off;
    assign stalled       = fs_q.stalled;
    assign busy          = (fs_q.st != ST_IDLE) || pending;
endmodule

// File: rtl/cmdq_consumer.sv
`timescale 1ns/1ps
module cmdq_consumer
    import cmdq_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int PAGES_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_wr_addr,
    input  logic [31:0]        reg_wr_data,
    input  logic [ADDR_W-1:0]  q_base,
    input  logic [PAGES_W-1:0] q_pages,
    output logic [31:0]        wptr_reg,
    output logic [31:0]        rptr_reg,
    output logic               busy,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [63:0]        mem_rsp_data,
    input  logic               mem_rsp_err,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [7:0]         cmd_opcode,
    output logic [3:0]         cmd_kind,
    output logic [255:0]       cmd_dw,
    input  logic               cmd_err
);
    localparam int HI_PAD = REG_W - OFF_W - OFF_LSB;

    logic             enable, retry, stalled;
    logic [OFF_W-1:0] wr_off, rd_off;
    cmd_kind_e        kind;

    cmdq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .enable  (enable),
        .wr_off  (wr_off),
        .retry   (retry)
    );

    cmdq_fetch #(
        .ADDR_W  (ADDR_W),
        .PAGES_W (PAGES_W)
    ) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .wr_off        (wr_off),
        .retry         (retry),
        .q_base        (q_base),
        .q_pages       (q_pages),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_err       (cmd_err),
        .cmd_dw        (cmd_dw),
        .rd_off        (rd_off),
        .stalled       (stalled),
        .busy          (busy)
    );

    cmdq_decode u_decode (
        .opcode (cmd_dw[OPC_W-1:0]),
        .kind   (kind)
    );

    assign cmd_opcode = cmd_dw[OPC_W-1:0];
    assign cmd_kind   = kind;
    assign wptr_reg   = {{HI_PAD{1'b0}}, wr_off, {OFF_LSB{1'b0}}};
    assign rptr_reg   = {{HI_PAD{1'b0}}, rd_off, {(OFF_LSB-1){1'b0}}, stalled};
endmodule

// File: rtl/cmdq_consumer_chk.sv
`timescale 1ns/1ps
module cmdq_consumer_chk #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [31:0]       rptr_reg,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_err,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_err,
    input logic [255:0]      cmd_dw
);
    logic unused_rptr;
    assign unused_rptr = ^{rptr_reg[31:20], rptr_reg[4:1]};

    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_dw));

    a_r8_offset_moves_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rptr_reg[19:5]) |-> $past(cmd_valid && cmd_ready && !cmd_err));

    a_r9_stall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rptr_reg[0]) |-> $past((mem_rsp_valid && mem_rsp_err) || (cmd_valid && cmd_ready && cmd_err)));

    a_r9_quiet_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        rptr_reg[0] |-> !mem_req_valid && !cmd_valid);

    a_r11_busy_covers_activity: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || cmd_valid) |-> busy);

    a_r5_fetch_dispatch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && cmd_valid));
endmodule

bind cmdq_consumer cmdq_consumer_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .rptr_reg      (rptr_reg),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_err       (cmd_err),
    .cmd_dw        (cmd_dw)
);

// File: tb/test_cmdq_consumer.sv
`timescale 1ns/1ps
module test_cmdq_consumer;
    localparam int ADDR_W  = 48;
    localparam int PAGES_W = 9;
    localparam logic [ADDR_W-1:0] BASE = 48'h0000_1234_5000;
    localparam int NVEC = 11;
    // opcode, expected kind
    localparam logic [11:0] VEC [NVEC] = '{
        {8'h03, 4'd1}, {8'h04, 4'd2}, {8'h05, 4'd3}, {8'h08, 4'd4},
        {8'h09, 4'd5}, {8'h0A, 4'd6}, {8'h0B, 4'd7}, {8'h0F, 4'd8},
        {8'h00, 4'd0}, {8'hFF, 4'd0}, {8'h06, 4'd0}
    };

    logic               clk, rst_n;
    logic               reg_wr_en;
    logic [1:0]         reg_wr_addr;
    logic [31:0]        reg_wr_data;
    logic [ADDR_W-1:0]  q_base;
    logic [PAGES_W-1:0] q_pages;
    logic [31:0]        wptr_reg, rptr_reg;
    logic               busy;
    logic               mem_req_valid, mem_req_ready;
    logic [ADDR_W-1:0]  mem_req_addr;
    logic               mem_rsp_valid, mem_rsp_err;
    logic [63:0]        mem_rsp_data;
    logic               cmd_valid, cmd_ready, cmd_err;
    logic [7:0]         cmd_opcode;
    logic [3:0]         cmd_kind;
    logic [255:0]       cmd_dw;

    int checks = 0, errors = 0;
    int exp_rd = 0, reqk = 0, cmd_count = 0, req_count = 0;
    int err_entry = 0, err_k = 0;
    bit err_arm = 0, exec_err_next = 0, pend = 0;
    logic [ADDR_W-1:0] pend_addr;
    logic [7:0] op_mem [64];
    logic [3:0] kind_mem [64];
    logic [3:0] last_kind;
    int me, mk;

    cmdq_consumer #(.ADDR_W(ADDR_W), .PAGES_W(PAGES_W)) i_cmdq_consumer (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .q_base(q_base), .q_pages(q_pages),
        .wptr_reg(wptr_reg), .rptr_reg(rptr_reg), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
        .cmd_kind(cmd_kind), .cmd_dw(cmd_dw), .cmd_err(cmd_err)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    assign cmd_err = exec_err_next & cmd_valid;

    function automatic logic [63:0] mem_dw(int e, int k, logic [7:0] op);
        return {16'hBEEF, 16'(e), 16'(k), 8'h5A, (k == 0) ? op : 8'h00};
    endfunction

    function automatic logic [31:0] rp(int off, bit st);
        return 32'(off << 5) | 32'(st);
    endfunction

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory responder and executor monitor, both away from the active edge
    always @(negedge clk) begin
        if (pend) begin
            me = int'((pend_addr - BASE) >> 5);
            mk = int'(pend_addr[4:3]);
            mem_rsp_valid = 1'b1;
            mem_rsp_err   = err_arm && (me == err_entry) && (mk == err_k);
            mem_rsp_data  = mem_dw(me, mk, op_mem[me % 64]);
            if (mem_rsp_err) reqk = 0;
            pend = 0;
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
        end
        if (rst_n && mem_req_valid && mem_req_ready) begin
            check_eq("R5 fetch address", 64'(mem_req_addr),
                     64'(BASE + ADDR_W'(exp_rd * 32) + ADDR_W'(reqk * 8)));
            reqk++;
            req_count++;
            pend = 1;
            pend_addr = mem_req_addr;
        end
        if (rst_n && cmd_valid && cmd_ready) begin
            check_eq("R6 entry doublewords", 64'(cmd_dw == {mem_dw(exp_rd, 3, 8'h00), mem_dw(exp_rd, 2, 8'h00),
                     mem_dw(exp_rd, 1, 8'h00), mem_dw(exp_rd, 0, op_mem[exp_rd % 64])}), 64'd1);
            check_eq("R6 opcode byte", 64'(cmd_opcode), 64'(op_mem[exp_rd % 64]));
            check_eq("R6 R7 kind", 64'(cmd_kind), 64'(kind_mem[exp_rd % 64]));
            last_kind = cmd_kind;
            cmd_count++;
            if (!cmd_err) exp_rd = (exp_rd + 1) % (int'(q_pages) * 128);
            reqk = 0;
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_wptr(input int off, input bit rty);
        reg_write(2'd1, 32'(off << 5) | 32'(rty));
    endtask

    task automatic wait_idle(input int lim);
        int n = 0;
        while (busy && n < lim) begin
            @(negedge clk);
            n++;
        end
        check_eq("R11 returns idle", 64'(busy), 64'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int rc, cc;
        for (int i = 0; i < 64; i++) begin op_mem[i] = 8'h05; kind_mem[i] = 4'd3; end
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
        q_base = BASE; q_pages = 9'd1; mem_req_ready = 1'b1; cmd_ready = 1'b1;
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 rptr", 64'(rptr_reg), 64'd0);
        check_eq("R1 wptr", 64'(wptr_reg), 64'd0);
        check_eq("R1 busy", 64'(busy), 64'd0);
        check_eq("R1 req", 64'(mem_req_valid), 64'd0);
        check_eq("R1 cmd", 64'(cmd_valid), 64'd0);

        // R2 field extraction, R3 disabled
        reg_write(2'd1, 32'hFFF0_0020);
        check_eq("R2 wptr field", 64'(wptr_reg), 64'h20);
        reg_write(2'd2, 32'h1);
        reg_write(2'd3, 32'h1);
        repeat (20) @(negedge clk);
        check_eq("R2 R3 no fetch when disabled", 64'(req_count), 64'd0);
        check_eq("R3 busy low when disabled", 64'(busy), 64'd0);

        reg_write(2'd0, 32'h1);
        wait_idle(200);
        check_eq("R8 first entry", 64'(rptr_reg), 64'(rp(1, 0)));

        // vector table: opcode classification
        for (int i = 0; i < NVEC; i++) begin
            int e;
            e = exp_rd;
            op_mem[e] = VEC[i][11:4];
            kind_mem[e] = VEC[i][3:0];
            set_wptr(e + 1, 0);
            wait_idle(200);
            check_eq("R8 offset after vector", 64'(rptr_reg), 64'(rp(e + 1, 0)));
            check_eq((VEC[i][3:0] == 4'd0) ? "R7 unknown opcode kind" : "R6 opcode kind",
                     64'(last_kind), 64'(VEC[i][3:0]));
        end

        // back-to-back batch
        cc = cmd_count;
        set_wptr(17, 0);
        wait_idle(500);
        check_eq("R8 batch offset", 64'(rptr_reg), 64'(rp(17, 0)));
        check_eq("R8 batch count", 64'(cmd_count - cc), 64'd5);

        // R5 request held without ready
        mem_req_ready = 1'b0;
        set_wptr(18, 0);
        repeat (5) @(negedge clk);
        check_eq("R5 request held", 64'(mem_req_valid), 64'd1);
        check_eq("R5 held address", 64'(mem_req_addr), 64'(BASE + ADDR_W'(17 * 32)));
        check_eq("R11 busy while held", 64'(busy), 64'd1);
        @(posedge clk); #1 mem_req_ready = 1'b1;
        wait_idle(200);
        check_eq("R5 after hold", 64'(rptr_reg), 64'(rp(18, 0)));

        // R4 out-of-range write offset
        rc = req_count;
        set_wptr(128, 0);
        repeat (20) @(negedge clk);
        check_eq("R4 rejected offset no fetch", 64'(req_count - rc), 64'd0);
        check_eq("R4 busy low", 64'(busy), 64'd0);
        check_eq("R4 rptr unchanged", 64'(rptr_reg), 64'(rp(18, 0)));
        @(negedge clk); q_pages = 9'd0;
        set_wptr(19, 0);
        repeat (20) @(negedge clk);
        check_eq("R4 zero pages no fetch", 64'(req_count - rc), 64'd0);
        check_eq("R4 zero pages busy", 64'(busy), 64'd0);
        q_pages = 9'd1;
        @(negedge clk);
        wait_idle(200);
        check_eq("R4 restored size resumes", 64'(rptr_reg), 64'(rp(19, 0)));

        // R8 wraparound
        cc = cmd_count;
        set_wptr(2, 0);
        wait_idle(5000);
        check_eq("R8 wrap offset", 64'(rptr_reg), 64'(rp(2, 0)));
        check_eq("R8 wrap count", 64'(cmd_count - cc), 64'd111);

        // R9 fetch error and R10 retry
        err_entry = 2; err_k = 2; err_arm = 1;
        cc = cmd_count;
        set_wptr(3, 0);
        wait_idle(200);
        check_eq("R9 fetch error stall", 64'(rptr_reg), 64'(rp(2, 1)));
        check_eq("R9 no dispatch", 64'(cmd_count - cc), 64'd0);
        rc = req_count;
        repeat (20) @(negedge clk);
        check_eq("R9 no requests while stalled", 64'(req_count - rc), 64'd0);
        set_wptr(3, 0);
        repeat (10) @(negedge clk);
        check_eq("R10 plain write keeps stall", 64'(rptr_reg), 64'(rp(2, 1)));
        set_wptr(3, 1);
        wait_idle(200);
        check_eq("R10 retry fails again", 64'(rptr_reg), 64'(rp(2, 1)));
        err_arm = 0;
        set_wptr(3, 1);
        wait_idle(200);
        check_eq("R10 retry resumes", 64'(rptr_reg), 64'(rp(3, 0)));
        check_eq("R10 one entry done", 64'(cmd_count - cc), 64'd1);

        // R9 executor error
        exec_err_next = 1;
        cc = cmd_count;
        set_wptr(4, 0);
        wait_idle(200);
        check_eq("R9 executor error stall", 64'(rptr_reg), 64'(rp(3, 1)));
        check_eq("R9 entry offered once", 64'(cmd_count - cc), 64'd1);
        exec_err_next = 0;
        set_wptr(4, 1);
        wait_idle(200);
        check_eq("R10 retry after executor error", 64'(rptr_reg), 64'(rp(4, 0)));

        // R12 disable while an entry is in flight
        set_wptr(7, 0);
        reg_write(2'd0, 32'h0);
        wait_idle(200);
        check_eq("R12 one entry completes", 64'(rptr_reg), 64'(rp(5, 0)));
        repeat (10) @(negedge clk);
        check_eq("R12 stays stopped", 64'(rptr_reg), 64'(rp(5, 0)));
        reg_write(2'd0, 32'h1);
        wait_idle(200);
        check_eq("R3 re-enable drains", 64'(rptr_reg), 64'(rp(7, 0)));

        finish_run();
    end
endmodule